// File: doc/BRIEF.md
# Iterative Multiply-Accumulate Unit

This block is the multiplier of a small processor core. A request carries two 32-bit factors, a 32-bit addend for the short accumulate form, a 64-bit accumulator split into a high and a low word for the long accumulate forms, and a 3-bit operation code. The unit works through the product one multiplier bit per cycle using a shift-add loop on operand magnitudes. It then applies the sign, adds the addend or accumulator, and presents a 64-bit result split into two words, together with negative and zero flags.

The request side is a valid/ready handshake. `in_ready` is high only while the unit is idle. A request is taken in a cycle where `in_valid` and `in_ready` are both high. While a request is being worked on, `in_ready` stays low and `in_valid` has no effect. The result side has no back-pressure. `res_valid` is a single-cycle strobe, and the result words and flags hold their value until the next strobe. A new request may be offered in the same cycle as the strobe.

Operation codes: 0 short multiply, 1 short multiply-add, 2 unsigned long multiply, 3 unsigned long multiply-accumulate, 4 signed long multiply, 5 signed long multiply-accumulate. Codes 6 and 7 act as 4 and 5.

Top module: `mul_acc_unit`

## Requirements
- R1: Code 0 gives `res_lo` = low 32 bits of m·s and `res_hi` = 0.
- R2: Code 1 gives `res_lo` = low 32 bits of m·s + addend and `res_hi` = 0.
- R3: Code 2 gives {`res_hi`,`res_lo`} = the full 64-bit unsigned product m·s.
- R4: Code 3 gives {`res_hi`,`res_lo`} = (m·s + {acc_hi,acc_lo}) mod 2^64, with all values unsigned.
- R5: Code 4 (and code 6) gives the 64-bit two's-complement product of signed m and s.
- R6: Code 5 (and code 7) gives (signed m·s + {acc_hi,acc_lo}) mod 2^64, in two's complement.
- R7: A signed product of 0x80000000 × 0x80000000 gives +2^62 (hi 0x40000000, lo 0), with no sign error.
- R8: `res_valid` rises on the 34th rising edge counted from and including the edge that accepts the request, and stays high for exactly one cycle.
- R9: `in_ready` is low from acceptance until the strobe. A request offered in that time is dropped and does not change the result.
- R10: `res_n` equals bit 63 of the result for codes 2–7 and bit 31 of `res_lo` for codes 0–1.
- R11: `res_z` is 1 exactly when the written width is all zero: 64 bits for codes 2–7, 32 bits for codes 0–1.
- R12: After reset, and after a reset that arrives during a computation, `in_ready` = 1, `res_valid` = 0, and the result words and flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Unit idle, request will be taken |
| in_op | input | 3 | Operation code |
| in_m | input | 32 | First factor |
| in_s | input | 32 | Second factor |
| in_add | input | 32 | Addend for code 1 |
| in_acc_hi | input | 32 | Accumulator high word for codes 3, 5, 7 |
| in_acc_lo | input | 32 | Accumulator low word for codes 3, 5, 7 |
| res_valid | output | 1 | One-cycle result strobe |
| res_hi | output | 32 | Result high word |
| res_lo | output | 32 | Result low word |
| res_n | output | 1 | Negative flag |
| res_z | output | 1 | Zero flag |

## Verification
The bench targets the most negative signed operand squared. A design that takes the magnitude with too few bits, or that sign-extends the magnitude, returns a negative or doubled value there. It also drives results that wrap to zero only after the addend or accumulator is added. A unit that tests the flags on the product alone, or over the wrong width, reports the wrong Z or N flag. All-ones factors in both signed and unsigned forms expose a mix-up of the sign handling. A second request held high during a computation shows whether a unit restarts, strobes twice, or corrupts its operands.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } mac_state_e;

  typedef struct packed {
    logic is_long;
    logic is_signed;
    logic accum;
  } mac_ctl_t;

  function automatic mac_ctl_t decode_op(input logic [2:0] op);
    mac_ctl_t c;
    c.is_long   = op[2] | op[1];
    c.is_signed = op[2];
    c.accum     = op[0];
    return c;
  endfunction

endpackage

// File: rtl/mac_operand_prep.sv
module mac_operand_prep #(
  parameter int W = 32
) (
  input  logic [W-1:0] m,
  input  logic [W-1:0] s,
  input  logic         is_signed,
  output logic [W-1:0] mag_m,
  output logic [W-1:0] mag_s,
  output logic         negate
);
  logic m_neg, s_neg;

  // Magnitude of the most negative value is 2^(W-1), which still fits W unsigned bits.
  assign m_neg  = is_signed & m[W-1];
  assign s_neg  = is_signed & s[W-1];
  assign mag_m  = m_neg ? (~m + W'(1)) : m;
  assign mag_s  = s_neg ? (~s + W'(1)) : s;
  assign negate = m_neg ^ s_neg;
endmodule

// File: rtl/mac_shift_add.sv
module mac_shift_add #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [W-1:0]   mag_m,
  input  logic [W-1:0]   mag_s,
  output logic [2*W-1:0] prod
);
  localparam int PW = 2 * W;

  logic [PW-1:0] acc_q;
  logic [PW-1:0] mcand_q;
  logic [W-1:0]  mplr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      mcand_q <= '0;
      mplr_q  <= '0;
    end else if (load) begin
      acc_q   <= '0;
      mcand_q <= {{W{1'b0}}, mag_m};
      mplr_q  <= mag_s;
    end else if (step) begin
      if (mplr_q[0]) acc_q <= acc_q + mcand_q;
      mcand_q <= mcand_q << 1;
      mplr_q  <= mplr_q >> 1;
    end
  end

  assign prod = acc_q;
endmodule

// File: rtl/mac_finalize.sv
module mac_finalize
  import mac_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [2*W-1:0] prod,
  input  logic           negate,
  input  mac_ctl_t       ctl,
  input  logic [W-1:0]   addend,
  input  logic [2*W-1:0] acc_in,
  output logic [W-1:0]   hi,
  output logic [W-1:0]   lo,
  output logic           flag_n,
  output logic           flag_z
);
  localparam int PW = 2 * W;

  logic [PW-1:0] sprod;
  logic [PW-1:0] long_sum;
  logic [W-1:0]  short_sum;

  always_comb begin
    sprod     = negate ? (~prod + PW'(1)) : prod;
    long_sum  = sprod + (ctl.accum ? acc_in : '0);
    short_sum = sprod[W-1:0] + (ctl.accum ? addend : '0);
    if (ctl.is_long) begin
      hi     = long_sum[PW-1:W];
      lo     = long_sum[W-1:0];
      flag_n = long_sum[PW-1];
      flag_z = (long_sum == '0);
    end else begin
      hi     = '0;
      lo     = short_sum;
      flag_n = short_sum[W-1];
      flag_z = (short_sum == '0);
    end
  end
endmodule

// File: rtl/mul_acc_unit.sv
module mul_acc_unit
  import mac_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [2:0]   in_op,
  input  logic [W-1:0] in_m,
  input  logic [W-1:0] in_s,
  input  logic [W-1:0] in_add,
  input  logic [W-1:0] in_acc_hi,
  input  logic [W-1:0] in_acc_lo,
  output logic         res_valid,
  output logic [W-1:0] res_hi,
  output logic [W-1:0] res_lo,
  output logic         res_n,
  output logic         res_z
);
  localparam int PW = 2 * W;
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  mac_state_e    state_q;
  logic [CW-1:0] cnt_q;
  mac_ctl_t      ctl_q, ctl_in;
  logic          neg_q;
  logic [W-1:0]  add_q;
  logic [PW-1:0] accin_q;
  logic          accept;

  logic [W-1:0]  mag_m, mag_s;
  logic          negate;
  logic [PW-1:0] prod;
  logic [W-1:0]  fin_hi, fin_lo;
  logic          fin_n, fin_z;

  assign ctl_in   = decode_op(in_op);
  assign in_ready = (state_q == ST_IDLE);
  assign accept   = in_valid && in_ready;

  mac_operand_prep #(.W(W)) u_prep (
    .m(in_m), .s(in_s), .is_signed(ctl_in.is_signed),
    .mag_m(mag_m), .mag_s(mag_s), .negate(negate)
  );

  mac_shift_add #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .load(accept), .step(state_q == ST_RUN),
    .mag_m(mag_m), .mag_s(mag_s), .prod(prod)
  );

  mac_finalize #(.W(W)) u_fin (
    .prod(prod), .negate(neg_q), .ctl(ctl_q), .addend(add_q), .acc_in(accin_q),
    .hi(fin_hi), .lo(fin_lo), .flag_n(fin_n), .flag_z(fin_z)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      ctl_q     <= '0;
      neg_q     <= 1'b0;
      add_q     <= '0;
      accin_q   <= '0;
      res_valid <= 1'b0;
      res_hi    <= '0;
      res_lo    <= '0;
      res_n     <= 1'b0;
      res_z     <= 1'b0;
    end else begin
      res_valid <= (state_q == ST_FIN);
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            ctl_q   <= ctl_in;
            neg_q   <= negate;
            add_q   <= in_add;
            accin_q <= {in_acc_hi, in_acc_lo};
            cnt_q   <= '0;
            state_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          cnt_q <= cnt_q + CW'(1);
          if (cnt_q == LAST) state_q <= ST_FIN;
        end
        ST_FIN: begin
          res_hi  <= fin_hi;
          res_lo  <= fin_lo;
          res_n   <= fin_n;
          res_z   <= fin_z;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mul_acc_unit_checker.sv
module mul_acc_unit_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [2:0]   in_op,
  input logic         res_valid,
  input logic [W-1:0] res_hi,
  input logic [W-1:0] res_lo,
  input logic         res_n,
  input logic         res_z
);
  localparam logic [7:0] EXP_CNT = 8'(W + 2);

  logic       lat_long;
  logic [7:0] since_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_long <= 1'b0;
      since_q  <= '0;
    end else begin
      if (in_valid && in_ready) lat_long <= in_op[2] | in_op[1];
      if (in_valid && in_ready)                  since_q <= 8'd1;
      else if (res_valid)                        since_q <= '0;
      else if (since_q != 0 && since_q != 8'hFF) since_q <= since_q + 8'd1;
    end
  end

  assert_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> since_q == EXP_CNT);

  assert_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  assert_short_hi_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !lat_long) |-> res_hi == '0);

  assert_nflag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_n == (lat_long ? res_hi[W-1] : res_lo[W-1]));

  assert_zflag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_z == (lat_long ? ({res_hi, res_lo} == '0) : (res_lo == '0)));
endmodule

bind mul_acc_unit mul_acc_unit_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .res_valid(res_valid), .res_hi(res_hi), .res_lo(res_lo),
  .res_n(res_n), .res_z(res_z)
);

// File: tb/mul_acc_unit_bench.sv
module mul_acc_unit_bench;
  localparam int NV = 17;
  // {op, m, s, addend, acc_hi, acc_lo}
  localparam logic [162:0] VECS [NV] = '{
    {3'd0, 32'h12345678, 32'h9ABCDEF0, 32'h0, 32'h0, 32'h0},
    {3'd0, 32'h00000000, 32'h00000005, 32'h0, 32'h0, 32'h0},
    {3'd0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0, 32'h0, 32'h0},
    {3'd1, 32'h00000003, 32'h00000005, 32'h7, 32'h0, 32'h0},
    {3'd1, 32'h00000001, 32'hFFFFFFFF, 32'h1, 32'h0, 32'h0},
    {3'd1, 32'h7FFFFFFF, 32'h00000002, 32'h0, 32'h0, 32'h0},
    {3'd2, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0, 32'h0, 32'h0},
    {3'd2, 32'h80000000, 32'h00000002, 32'h0, 32'h0, 32'h0},
    {3'd3, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0, 32'hFFFFFFFF, 32'hFFFFFFFF},
    {3'd3, 32'h00000001, 32'h00000001, 32'h0, 32'hFFFFFFFF, 32'hFFFFFFFF},
    {3'd4, 32'h80000000, 32'h80000000, 32'h0, 32'h0, 32'h0},
    {3'd4, 32'hFFFFFFFF, 32'h00000007, 32'h0, 32'h0, 32'h0},
    {3'd4, 32'h7FFFFFFF, 32'h80000000, 32'h0, 32'h0, 32'h0},
    {3'd5, 32'hFFFFFFFF, 32'h00000001, 32'h0, 32'h0, 32'h00000001},
    {3'd5, 32'h80000000, 32'h80000000, 32'h0, 32'h0, 32'h0},
    {3'd6, 32'hFFFFFFFE, 32'h00000003, 32'h0, 32'h0, 32'h0},
    {3'd7, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0, 32'hFFFFFFFF, 32'hFFFFFFFF}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_op = '0;
  logic [31:0] in_m = '0, in_s = '0, in_add = '0, in_acc_hi = '0, in_acc_lo = '0;
  logic        res_valid;
  logic [31:0] res_hi, res_lo;
  logic        res_n, res_z;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  mul_acc_unit u_mul_acc_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_m(in_m), .in_s(in_s), .in_add(in_add),
    .in_acc_hi(in_acc_hi), .in_acc_lo(in_acc_lo), .res_valid(res_valid),
    .res_hi(res_hi), .res_lo(res_lo), .res_n(res_n), .res_z(res_z)
  );

  task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [65:0] ref_calc(input logic [2:0] op, input logic [31:0] m, s, a, hi, lo);
    logic [63:0] pu, ps, r;
    logic        is_long;
    pu = {32'b0, m} * {32'b0, s};
    ps = $signed({{32{m[31]}}, m}) * $signed({{32{s[31]}}, s});
    is_long = 1'b1;
    case (op)
      3'd0: begin r = {32'b0, pu[31:0]}; is_long = 1'b0; end
      3'd1: begin r = {32'b0, pu[31:0] + a}; is_long = 1'b0; end
      3'd2: r = pu;
      3'd3: r = pu + {hi, lo};
      3'd4, 3'd6: r = ps;
      default: r = ps + {hi, lo};
    endcase
    if (is_long) return {r[63], (r == 64'd0), r};
    return {r[31], (r[31:0] == 32'd0), r};
  endfunction

  function automatic string op_req(input logic [2:0] op, input logic [31:0] m, s);
    if (op[2] && m == 32'h80000000 && s == 32'h80000000) return "R7";
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4, 3'd6: return "R5";
      default: return "R6";
    endcase
  endfunction

  // Offers one request, waits for the strobe; returns the number of negedges seen.
  task automatic issue(input logic [2:0] op, input logic [31:0] m, s, a, hi, lo, output int lat);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_op = op; in_m = m; in_s = s; in_add = a; in_acc_hi = hi; in_acc_lo = lo;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    lat = 1;
    while (!res_valid && lat < 100) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #800000;
    tests++;
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
    finish_run();
  end

  initial begin
    int lat;
    logic [65:0] e;
    logic [63:0] got;
    string req;

    // R12: reset state
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1 && res_valid == 1'b0, "R12", {62'b0, in_ready, res_valid}, 64'd2);
    check({res_hi, res_lo} == 64'd0 && !res_n && !res_z, "R12", {res_hi, res_lo}, 64'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [162:0] v;
      v = VECS[i];
      issue(v[162:160], v[159:128], v[127:96], v[95:64], v[63:32], v[31:0], lat);
      e = ref_calc(v[162:160], v[159:128], v[127:96], v[95:64], v[63:32], v[31:0]);
      req = op_req(v[162:160], v[159:128], v[127:96]);
      got = {res_hi, res_lo};
      check(got == e[63:0], req, got, e[63:0]);
      check(res_n == e[65], "R10", {63'b0, res_n}, {63'b0, e[65]});
      check(res_z == e[64], "R11", {63'b0, res_z}, {63'b0, e[64]});
      check(lat == 34, "R8", 64'(lat), 64'd34);
      @(negedge clk);
      check(res_valid == 1'b0, "R8", {63'b0, res_valid}, 64'd0);
    end

    // R7: explicit magnitude check
    issue(3'd4, 32'h80000000, 32'h80000000, 32'h0, 32'h0, 32'h0, lat);
    check({res_hi, res_lo} == 64'h4000000000000000, "R7", {res_hi, res_lo}, 64'h4000000000000000);

    // R9: request while busy is dropped
    begin
      int strobes;
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_op = 3'd2; in_m = 32'd1000; in_s = 32'd3000; in_add = 0; in_acc_hi = 0; in_acc_lo = 0;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      repeat (4) @(negedge clk);
      check(in_ready == 1'b0, "R9", {63'b0, in_ready}, 64'd0);
      in_op = 3'd0; in_m = 32'd7; in_s = 32'd9; in_valid = 1'b1;
      repeat (6) @(negedge clk);
      check(in_ready == 1'b0, "R9", {63'b0, in_ready}, 64'd0);
      in_valid = 1'b0;
      lat = 0;
      while (!res_valid && lat < 100) begin @(negedge clk); lat++; end
      check({res_hi, res_lo} == 64'd3000000, "R9", {res_hi, res_lo}, 64'd3000000);
      strobes = 0;
      for (int k = 0; k < 45; k++) begin
        @(negedge clk);
        if (res_valid) strobes++;
      end
      check(strobes == 0, "R9", 64'(strobes), 64'd0);
      check({res_hi, res_lo} == 64'd3000000, "R9", {res_hi, res_lo}, 64'd3000000);
    end

    // R12: reset in the middle of a computation
    @(negedge clk);
    in_op = 3'd2; in_m = 32'hFFFF; in_s = 32'hFFFF; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(in_ready == 1'b1 && res_valid == 1'b0, "R12", {62'b0, in_ready, res_valid}, 64'd2);
    check({res_hi, res_lo} == 64'd0, "R12", {res_hi, res_lo}, 64'd0);
    rst_n = 1'b1;
    begin
      int seen;
      seen = 0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (res_valid) seen++;
      end
      check(seen == 0, "R12", 64'(seen), 64'd0);
    end

    // unit still works after the mid-run reset
    issue(3'd1, 32'd6, 32'd7, 32'd8, 32'd0, 32'd0, lat);
    check({res_hi, res_lo} == 64'd50, "R2", {res_hi, res_lo}, 64'd50);

    finish_run();
  end
endmodule